// File: doc/BRIEF.md
# Ethernet transmit status tracker

This block keeps the per-frame transmit status flags of an Ethernet MAC that runs in half or full duplex. It watches event strobes from a transmit engine: frame start, frame end, collision, late collision, carrier loss, multicast destination, and a signal-quality-error (SQE) pulse inside a gap window. From these strobes it keeps sticky flags for single collision, multiple collision, collision limit reached, last-frame multicast, SQE test failure and transmit success.

The block also owns the transmit-enable bit. Software writes that bit through a write strobe and a value. The block forces the bit low when a frame reaches the collision limit. Fatal errors are classified only in half duplex. Which errors count as fatal depends on the stop-on-SQE and carrier-monitor options. All strobes are single-cycle pulses that the block samples on the rising clock edge. Every flag updates on the edge that samples its cause.

Top module: `tx_status_tracker`

## Requirements
- R1: An active-low hardware reset, or a high software-reset input, clears every flag, the collision count and transmit-enable on the next edge. The software reset has priority over every other input.
- R2: A write with value 1 sets transmit-enable. The same edge clears the collision-limit, SQE-fail and success flags. A write with value 0 clears transmit-enable and leaves every flag unchanged.
- R3: A frame-start strobe while transmit-enable is low is ignored. The collision count, the per-frame latches, the success flag and the multicast flag all keep their values.
- R4: The collision count returns to 0 on an accepted frame start. In half duplex it adds 1 for each collision strobe. It saturates at 16, so later collision strobes are ignored.
- R5: The single-collision flag sets on any counted collision. The multiple-collision flag sets when the count reaches 2 or more. Both flags clear when a frame ends successfully, and at no other time. The multiple-collision flag is never high while the single-collision flag is low.
- R6: On the collision that brings the count to 16, the collision-limit flag sets and transmit-enable goes low on the same edge. Only a write of 1 to transmit-enable clears the flag.
- R7: The multicast flag clears on each accepted frame start. It sets on any cycle in which the multicast input is high.
- R8: A frame-end strobe with no fatal error sets the success flag. An accepted frame start clears it, and so does a write of 1 to transmit-enable.
- R9: In half duplex, four conditions within the current frame are fatal: a collision count of 16; SQE failure while stop-on-SQE is 1; carrier loss while carrier monitoring is 1; and a late collision. A fatal frame end leaves the success flag clear and does not clear the collision flags.
- R10: In half duplex with stop-on-SQE set, the SQE-fail flag sets at frame end if no pulse arrived while the SQE window was high since the last accepted frame start. The flag stays set across frames until transmit-enable is written 1 or a reset occurs.
- R11: In full duplex, the collision, late-collision, carrier-loss and SQE inputs have no effect. Every frame end sets the success flag.
- R12: A write of 1 to transmit-enable beats any set of the flags it clears in the same cycle. A frame start accepted in the same cycle as a multicast or collision strobe applies its clear first, so the new event counts for the new frame. A frame start and a frame end in the same cycle leave the success flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| sw_rst | input | 1 | Software reset, active high |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| stop_sqe | input | 1 | Treat a missing SQE pulse as fatal |
| mon_crs | input | 1 | Treat carrier loss as fatal |
| txw_en | input | 1 | Write strobe for transmit-enable |
| txw_val | input | 1 | Value written to transmit-enable |
| frm_start | input | 1 | Frame transmission starts |
| frm_end | input | 1 | Frame transmission completes |
| col | input | 1 | Collision strobe |
| late_col | input | 1 | Late collision strobe |
| crs_lost | input | 1 | Carrier loss strobe |
| mcast | input | 1 | Current frame has a multicast destination |
| sqe_win | input | 1 | SQE observation window (gap) is open |
| sqe_pulse | input | 1 | SQE pulse seen on the line |
| tx_en | output | 1 | Transmit-enable bit |
| col_cnt | output | 5 | Collisions counted for the current frame |
| st_sngl_col | output | 1 | At least one collision |
| st_mult_col | output | 1 | More than one collision |
| st_col16 | output | 1 | Collision limit reached |
| st_last_mcast | output | 1 | Last frame was multicast |
| st_sqe_fail | output | 1 | SQE test failed |
| st_tx_ok | output | 1 | Last frame sent without fatal error |

## Verification
The bench aims at the seventeenth collision strobe. A counter without saturation would wrap or show 17, and would fire the limit edge a second time. It also drives a frame start while transmit-enable is low; a design that accepted it would wipe the count and the multicast flag. Same-cycle collisions of a re-enable write with a success set, and of a start with a multicast strobe, expose wrong priority as a stale success or a lost multicast flag. Full-duplex frames that carry every error input expose fatal logic that is not gated by duplex mode, because success would stay low. A long random run, with duplex mode and the options changing, compares every output on every cycle against a bench model.

// File: rtl/tx_status_tracker.sv
module tx_status_tracker #(
  parameter int COL_LIMIT = 16,
  localparam int CW = $clog2(COL_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          full_dup,
  input  logic          stop_sqe,
  input  logic          mon_crs,
  input  logic          txw_en,
  input  logic          txw_val,
  input  logic          frm_start,
  input  logic          frm_end,
  input  logic          col,
  input  logic          late_col,
  input  logic          crs_lost,
  input  logic          mcast,
  input  logic          sqe_win,
  input  logic          sqe_pulse,
  output logic          tx_en,
  output logic [CW-1:0] col_cnt,
  output logic          st_sngl_col,
  output logic          st_mult_col,
  output logic          st_col16,
  output logic          st_last_mcast,
  output logic          st_sqe_fail,
  output logic          st_tx_ok
);

  localparam logic [CW-1:0] LIM = CW'(COL_LIMIT);

  logic wr_hi, wr_lo, go, hdx, col_ok, hit_lim, sqe_bad, fatal, ok_end;
  logic late_q, crs_q, sqp_q, late_nx, crs_nx, sqp_nx;
  logic [CW-1:0] cnt_base, cnt_nx;

  assign wr_hi    = txw_en & txw_val;
  assign wr_lo    = txw_en & ~txw_val;
  assign go       = frm_start & tx_en;
  assign hdx      = ~full_dup;

  assign cnt_base = go ? '0 : col_cnt;
  assign col_ok   = col & hdx & (cnt_base != LIM);
  assign cnt_nx   = cnt_base + CW'(col_ok);
  assign hit_lim  = col_ok & (cnt_nx == LIM);

  assign late_nx  = (~go & late_q) | (late_col & hdx);
  assign crs_nx   = (~go & crs_q) | (crs_lost & hdx);
  assign sqp_nx   = (~go & sqp_q) | (sqe_win & sqe_pulse);

  assign sqe_bad  = hdx & stop_sqe & ~sqp_nx;
  assign fatal    = hdx & ((cnt_nx == LIM) | sqe_bad | (mon_crs & crs_nx) | late_nx);
  assign ok_end   = frm_end & ~fatal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0; col_cnt <= '0;
      late_q <= 1'b0; crs_q <= 1'b0; sqp_q <= 1'b0;
      st_sngl_col <= 1'b0; st_mult_col <= 1'b0; st_col16 <= 1'b0;
      st_last_mcast <= 1'b0; st_sqe_fail <= 1'b0; st_tx_ok <= 1'b0;
    end else if (sw_rst) begin
      tx_en <= 1'b0; col_cnt <= '0;
      late_q <= 1'b0; crs_q <= 1'b0; sqp_q <= 1'b0;
      st_sngl_col <= 1'b0; st_mult_col <= 1'b0; st_col16 <= 1'b0;
      st_last_mcast <= 1'b0; st_sqe_fail <= 1'b0; st_tx_ok <= 1'b0;
    end else begin
      col_cnt <= cnt_nx;
      late_q  <= late_nx;
      crs_q   <= crs_nx;
      sqp_q   <= sqp_nx;

      if (wr_hi)                tx_en <= 1'b1;
      else if (wr_lo | hit_lim) tx_en <= 1'b0;

      if (wr_hi)        st_col16 <= 1'b0;
      else if (hit_lim) st_col16 <= 1'b1;

      if (wr_hi)                  st_sqe_fail <= 1'b0;
      else if (frm_end & sqe_bad) st_sqe_fail <= 1'b1;

      if (wr_hi | go)   st_tx_ok <= 1'b0;
      else if (ok_end)  st_tx_ok <= 1'b1;

      if (ok_end)       st_sngl_col <= 1'b0;
      else if (col_ok)  st_sngl_col <= 1'b1;

      if (ok_end)                          st_mult_col <= 1'b0;
      else if (col_ok && cnt_nx >= CW'(2)) st_mult_col <= 1'b1;

      st_last_mcast <= (~go & st_last_mcast) | mcast;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (!tx_en && col_cnt == '0 && !st_tx_ok && !st_sngl_col && !st_mult_col
                && !st_col16 && !st_last_mcast && !st_sqe_fail));

  assert_reenable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (txw_en && txw_val && !sw_rst) |=> (tx_en && !st_col16 && !st_sqe_fail && !st_tx_ok));

  assert_blocked_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !tx_en && !sw_rst && !col) |=> (col_cnt == $past(col_cnt)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    col_cnt <= LIM);

  assert_mult_needs_sngl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_mult_col |-> st_sngl_col);

  assert_limit_drops_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_col16) |-> !tx_en);

  assert_fdx_success_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full_dup && frm_end && !frm_start && !txw_en && !sw_rst) |=> st_tx_ok);

endmodule

// File: tb/sim_tx_status_tracker.sv
module sim_tx_status_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 0, full_dup = 0, stop_sqe = 0, mon_crs = 0, txw_en = 0, txw_val = 0;
  logic frm_start = 0, frm_end = 0, col = 0, late_col = 0, crs_lost = 0, mcast = 0;
  logic sqe_win = 0, sqe_pulse = 0;
  logic tx_en, st_sngl_col, st_mult_col, st_col16, st_last_mcast, st_sqe_fail, st_tx_ok;
  logic [4:0] col_cnt;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit m_en, m_sg, m_mu, m_16, m_mc, m_sq, m_ok, m_late, m_crs, m_sqp;
  int m_cnt;

  always #5 clk = ~clk;

  tx_status_tracker u0 (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .full_dup(full_dup), .stop_sqe(stop_sqe),
    .mon_crs(mon_crs), .txw_en(txw_en), .txw_val(txw_val), .frm_start(frm_start),
    .frm_end(frm_end), .col(col), .late_col(late_col), .crs_lost(crs_lost), .mcast(mcast),
    .sqe_win(sqe_win), .sqe_pulse(sqe_pulse), .tx_en(tx_en), .col_cnt(col_cnt),
    .st_sngl_col(st_sngl_col), .st_mult_col(st_mult_col), .st_col16(st_col16),
    .st_last_mcast(st_last_mcast), .st_sqe_fail(st_sqe_fail), .st_tx_ok(st_tx_ok));

  task automatic chk(string req, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic m_clear();
    m_en = 0; m_sg = 0; m_mu = 0; m_16 = 0; m_mc = 0; m_sq = 0; m_ok = 0;
    m_late = 0; m_crs = 0; m_sqp = 0; m_cnt = 0;
  endtask

  // next state from the requirements
  task automatic m_update();
    bit st, hd, ok_c, lim, bad, fat, good;
    if (!rst_n || sw_rst) begin m_clear(); return; end
    st = frm_start && m_en;                       // R3
    hd = !full_dup;                               // R11
    if (st) begin m_cnt = 0; m_late = 0; m_crs = 0; m_sqp = 0; end
    ok_c = col && hd && m_cnt < 16;               // R4
    if (ok_c) m_cnt++;
    lim = ok_c && m_cnt == 16;
    if (late_col && hd) m_late = 1;
    if (crs_lost && hd) m_crs = 1;
    if (sqe_win && sqe_pulse) m_sqp = 1;
    bad = hd && stop_sqe && !m_sqp;               // R10
    fat = hd && (m_cnt == 16 || bad || (mon_crs && m_crs) || m_late);  // R9
    good = frm_end && !fat;
    if (st) m_mc = 0;                             // R7, R12
    if (mcast) m_mc = 1;
    if (txw_en && txw_val) m_en = 1; else if (txw_en || lim) m_en = 0;   // R2, R6
    if (txw_en && txw_val) m_16 = 0; else if (lim) m_16 = 1;
    if (txw_en && txw_val) m_sq = 0; else if (frm_end && bad) m_sq = 1;
    if ((txw_en && txw_val) || st) m_ok = 0; else if (good) m_ok = 1;   // R8
    if (good) begin m_sg = 0; m_mu = 0; end        // R5
    else if (ok_c) begin m_sg = 1; if (m_cnt >= 2) m_mu = 1; end
  endtask

  task automatic cmp_all();
    chk("R2", "tx_en", tx_en, m_en);
    chk("R4", "col_cnt", col_cnt, m_cnt);
    chk("R5", "sngl", st_sngl_col, m_sg);
    chk("R5", "mult", st_mult_col, m_mu);
    chk("R6", "col16", st_col16, m_16);
    chk("R7", "mcast", st_last_mcast, m_mc);
    chk("R10", "sqe_fail", st_sqe_fail, m_sq);
    chk("R8", "tx_ok", st_tx_ok, m_ok);
  endtask

  task automatic step();
    @(posedge clk);
    m_update();
    @(negedge clk);
    cmp_all();
    sw_rst = 0; txw_en = 0; txw_val = 0; frm_start = 0; frm_end = 0; col = 0;
    late_col = 0; crs_lost = 0; mcast = 0; sqe_win = 0; sqe_pulse = 0;
  endtask

  task automatic wr_en(bit v);
    txw_en = 1; txw_val = v; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "tx_en after reset", tx_en, 0);
    chk("R1", "col_cnt after reset", col_cnt, 0);
    chk("R1", "tx_ok after reset", st_tx_ok, 0);

    wr_en(1);
    chk("R2", "tx_en after write 1", tx_en, 1);

    // two collisions then good end
    frm_start = 1; step();
    col = 1; step();
    col = 1; step();
    chk("R5", "mult after 2 col", st_mult_col, 1);
    chk("R4", "count after 2 col", col_cnt, 2);
    frm_end = 1; step();
    chk("R5", "sngl cleared on success", st_sngl_col, 0);
    chk("R8", "tx_ok after good end", st_tx_ok, 1);

    // late collision fatal
    frm_start = 1; step();
    chk("R8", "tx_ok cleared at start", st_tx_ok, 0);
    col = 1; step();
    late_col = 1; step();
    frm_end = 1; step();
    chk("R9", "late collision blocks success", st_tx_ok, 0);
    chk("R9", "sngl kept on fatal end", st_sngl_col, 1);

    // carrier loss with monitoring
    mon_crs = 1;
    frm_start = 1; step();
    crs_lost = 1; step();
    frm_end = 1; step();
    chk("R9", "carrier loss fatal", st_tx_ok, 0);
    mon_crs = 0;

    // multicast with start, then plain start
    frm_start = 1; mcast = 1; step();
    chk("R12", "mcast with start kept", st_last_mcast, 1);
    frm_start = 1; step();
    chk("R7", "mcast cleared at start", st_last_mcast, 0);

    // SQE test
    stop_sqe = 1;
    frm_start = 1; step();
    frm_end = 1; step();
    chk("R10", "sqe fail without pulse", st_sqe_fail, 1);
    chk("R9", "sqe fail is fatal", st_tx_ok, 0);
    frm_start = 1; step();
    sqe_win = 1; sqe_pulse = 1; step();
    frm_end = 1; step();
    chk("R10", "sqe flag sticky", st_sqe_fail, 1);
    chk("R8", "pulse in window success", st_tx_ok, 1);
    wr_en(1);
    chk("R2", "sqe cleared by write 1", st_sqe_fail, 0);
    chk("R2", "tx_ok cleared by write 1", st_tx_ok, 0);
    stop_sqe = 0;

    // collision limit and saturation
    frm_start = 1; mcast = 1; step();
    for (int i = 0; i < 17; i++) begin col = 1; step(); end
    chk("R4", "count saturates", col_cnt, 16);
    chk("R6", "col16 set", st_col16, 1);
    chk("R6", "tx_en forced low", tx_en, 0);
    frm_start = 1; step();
    chk("R3", "blocked start keeps count", col_cnt, 16);
    chk("R3", "blocked start keeps mcast", st_last_mcast, 1);
    wr_en(0);
    chk("R2", "write 0 keeps col16", st_col16, 1);
    wr_en(1);
    chk("R6", "col16 cleared by write 1", st_col16, 0);

    // re-enable beats success set
    frm_start = 1; step();
    frm_end = 1; txw_en = 1; txw_val = 1; step();
    chk("R12", "write 1 beats success", st_tx_ok, 0);

    // full duplex ignores error inputs
    full_dup = 1; stop_sqe = 1; mon_crs = 1;
    frm_start = 1; step();
    col = 1; late_col = 1; crs_lost = 1; step();
    frm_end = 1; step();
    chk("R11", "fdx success", st_tx_ok, 1);
    chk("R11", "fdx no count", col_cnt, 0);
    chk("R11", "fdx no sqe", st_sqe_fail, 0);
    full_dup = 0; stop_sqe = 0; mon_crs = 0;

    // software reset
    mcast = 1; step();
    sw_rst = 1; col = 1; txw_en = 1; txw_val = 1; step();
    chk("R1", "sw reset tx_en", tx_en, 0);
    chk("R1", "sw reset mcast", st_last_mcast, 0);

    // constrained random
    void'($urandom(32'd4242));
    wr_en(1);
    for (int c = 0; c < 6000; c++) begin
      if (c % 700 == 0) full_dup = ($urandom % 3) == 0;
      if (c % 250 == 0) begin stop_sqe = $urandom % 2; mon_crs = $urandom % 2; end
      frm_start = ($urandom % 12) == 0;
      frm_end   = ($urandom % 12) == 0;
      col       = ($urandom % ((c / 1500) % 2 == 0 ? 8 : 3)) == 0;
      late_col  = ($urandom % 60) == 0;
      crs_lost  = ($urandom % 50) == 0;
      mcast     = ($urandom % 10) == 0;
      sqe_win   = ($urandom % 3) == 0;
      sqe_pulse = ($urandom % 2) == 0;
      txw_en    = ($urandom % 40) == 0;
      txw_val   = ($urandom % 5) != 0;
      sw_rst    = ($urandom % 900) == 0;
      if (c == 3000) begin rst_n = 0; step(); rst_n = 1; end
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule